// File: doc/BRIEF.md
# Packet-Granular Isochronous Byte Port

This block sits between an external byte-streaming device and an internal packet buffer. The device side is an 8-bit port run from the port clock. The device uses a single direction input to choose between sending, where it writes source packets into the buffer, and receiving, where it reads source packets out of the buffer. The internal side is the other end of the same buffer. It pops bytes of finished packets while sending, and it pushes bytes of received packets, each with an error flag, while receiving. The internal side can only pop or push packets that the device side is not using.

The handshake works on whole source packets. A registered ready output goes high only when a complete packet of room (sending) or a complete packet of data (receiving) is available. Once a packet has started, ready stays high until its last byte. A byte-valid input qualifies each byte, and the device may pause by dropping it. Ready has two modes. In drop-per-packet mode, ready falls after every packet. In hold mode, ready stays high while room or data remains. Every fall of ready is followed by a guaranteed quiet gap. A direction change flushes the buffer. A change to receive that arrives while the device is part-way through writing a packet waits until that packet is complete.

While receiving, the head packet is qualified by one of two flags. The good flag marks a clean packet and the error flag marks a bad one. Both are shown only while ready is high.

Top module: `iso_stream_port`

## Requirements
- R1: After reset the port is in receive mode with an empty buffer: `rdy_o`, `host_oe_o`, `err_o`, `good_o` and `net_avail_o` are 0, and `net_space_o` is 1.
- R2: `dir_i`=0 selects sending and `dir_i`=1 selects receiving. A change from receive to send flushes the buffer on the next rising edge, even in the middle of a packet read. `host_oe_o` then drops, and ready returns once the quiet gap has passed.
- R3: In send mode, a byte on `host_data_i` is stored on the rising edge where `host_valid_i` and `rdy_o` are both 1. `net_avail_o` is 1 while at least one complete packet (or the rest of one being popped) is held. `net_data_o` shows the popped byte one cycle after `net_pop_i`, in write order. `net_avail_o` and `net_space_o` are never 1 together.
- R4: In send mode, ready is 0 while `NUM_PKTS` complete packets are held. Bytes offered then are discarded. Ready returns after the internal side finishes popping a packet.
- R5: In receive mode, `net_push_i` bytes are stored only while `net_space_o` is 1. Ready rises once a complete packet is held. `host_data_o` is updated on the falling clock edge, so the byte taken at a rising edge with `host_valid_i` and `rdy_o` both 1 is the next byte in push order. `host_oe_o` is 1 only while receiving with ready high.
- R6: After any fall of `rdy_o`, it stays 0 for at least `GAP_CYCLES` (default 2) clock periods. With `hold_mode_i`=0, ready falls after the last byte of every packet.
- R7: With `hold_mode_i`=1, ready stays 1 across a packet boundary when room or data for another packet remains.
- R8: With `buf_en_i`=0, ready does not rise at a packet boundary. When ready is 0, it stays 0 for as long as `buf_en_i` is 0.
- R9: While receiving with ready high, `err_o`=1 if the head packet was pushed with `net_err_i`=1 on its last byte, and `good_o`=1 otherwise. The two flags are never both 1, and both are 0 when ready is 0.
- R10: Dropping `host_valid_i` in the middle of a packet pauses the transfer: ready stays 1 and no byte is taken.
- R11: A change to receive that arrives while a send packet is part-way written is deferred. The port stays in send mode until the last byte of that packet, then flushes the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | 0 = send, 1 = receive |
| hold_mode_i | input | 1 | 1 = hold mode, 0 = drop after each packet |
| buf_en_i | input | 1 | Buffer access enable for the device side |
| host_valid_i | input | 1 | Byte qualifier from the device |
| host_data_i | input | DW | Byte written by the device while sending |
| host_data_o | output | DW | Byte presented to the device while receiving |
| host_oe_o | output | 1 | Drive enable for `host_data_o` |
| rdy_o | output | 1 | Packet-level ready |
| err_o | output | 1 | Head received packet is bad |
| good_o | output | 1 | Head received packet is clean |
| net_pop_i | input | 1 | Internal side pops a byte (send mode) |
| net_data_o | output | DW | Popped byte, one cycle after the pop |
| net_avail_o | output | 1 | A packet is available to pop |
| net_push_i | input | 1 | Internal side pushes a byte (receive mode) |
| net_data_i | input | DW | Pushed byte |
| net_err_i | input | 1 | Error flag for the packet, sampled on its last byte |
| net_space_o | output | 1 | Room to push |

## Verification
The deferred direction switch is the hardest case to reach from the ports. The device has to be caught part-way through a send packet with `dir_i` already raised, and the flush has to be shown to wait for the final byte. The bench writes two bytes, raises `dir_i`, checks that the port still refuses pushes and keeps ready high, and then completes the packet. After that it sees the packet vanish, with `net_avail_o` at 0 and `net_space_o` at 1. A similar case is filling the buffer until ready stays down while bytes are still offered. The per-clock model then shows that none of those offered bytes reaches the internal side.

// File: rtl/iso_port_pkg.sv
package iso_port_pkg;
  typedef enum logic {
    DIR_SEND = 1'b0,
    DIR_RECV = 1'b1
  } dir_e;
endpackage

// File: rtl/iso_port_cursor.sv
// Packet-granular cursor: byte index within a packet slot and slot number.
module iso_port_cursor #(
  parameter int PKT_BYTES = 188,
  parameter int NUM_PKTS  = 4,
  parameter int IDX_W     = $clog2(PKT_BYTES),
  parameter int SLOT_W    = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1,
  parameter int ADDR_W    = $clog2(PKT_BYTES * NUM_PKTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              mid_next_o
);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(PKT_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_PKTS - 1);
  localparam logic [ADDR_W-1:0] PKT_SZ    = ADDR_W'(PKT_BYTES);

  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [SLOT_W-1:0] slot_q;

  assign last_o = step_i && !clr_i && (idx_q == LAST_IDX);

  always_comb begin
    if (clr_i)       idx_n = '0;
    else if (step_i) idx_n = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    else             idx_n = idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      idx_q  <= '0;
      slot_q <= '0;
    end else begin
      idx_q <= idx_n;
      if (last_o) slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
  end

  assign idx_o      = idx_q;
  assign slot_o     = slot_q;
  assign mid_next_o = (idx_n != '0);
  assign addr_o     = ADDR_W'(slot_q) * PKT_SZ + ADDR_W'(idx_q);
endmodule

// File: rtl/iso_port_ram.sv
// Byte store: one write port, a rising-edge read port for the internal side,
// a falling-edge read port for the device side.
module iso_port_ram #(
  parameter int DW     = 8,
  parameter int DEPTH  = 752,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              re_a_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DW-1:0]     rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DW-1:0]     rdata_b_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_a_i) rdata_a_o <= mem[raddr_a_i];
  end

  always_ff @(negedge clk) begin
    rdata_b_o <= mem[raddr_b_i];
  end
endmodule

// File: rtl/iso_port_ready.sv
// Registered packet-level ready with a minimum quiet gap after every fall.
module iso_port_ready #(
  parameter int GAP_CYCLES = 2,
  parameter int GAP_W      = $clog2(GAP_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic flush_i,
  input  logic mid_next_i,
  input  logic pkt_end_i,
  input  logic hold_mode_i,
  input  logic buf_en_i,
  input  logic pending_i,
  input  logic side_ok_i,
  output logic rdy_o
);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYCLES - 1);

  logic             rdy_q, rdy_n;
  logic [GAP_W-1:0] gap_q;

  always_comb begin
    if (flush_i)                        rdy_n = 1'b0;
    else if (mid_next_i)                rdy_n = 1'b1;
    else if (pkt_end_i && !hold_mode_i) rdy_n = 1'b0;
    else rdy_n = buf_en_i && !pending_i && (gap_q == '0) && side_ok_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= 1'b0;
      gap_q <= '0;
    end else begin
      rdy_q <= rdy_n;
      if (rdy_q && !rdy_n)  gap_q <= GAP_LOAD;
      else if (gap_q != '0) gap_q <= gap_q - 1'b1;
    end
  end

  assign rdy_o = rdy_q;
endmodule

// File: rtl/iso_stream_port.sv
module iso_stream_port #(
  parameter int PKT_BYTES  = 188,
  parameter int NUM_PKTS   = 4,
  parameter int GAP_CYCLES = 2,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_i,
  input  logic          hold_mode_i,
  input  logic          buf_en_i,
  input  logic          host_valid_i,
  input  logic [DW-1:0] host_data_i,
  output logic [DW-1:0] host_data_o,
  output logic          host_oe_o,
  output logic          rdy_o,
  output logic          err_o,
  output logic          good_o,
  input  logic          net_pop_i,
  output logic [DW-1:0] net_data_o,
  output logic          net_avail_o,
  input  logic          net_push_i,
  input  logic [DW-1:0] net_data_i,
  input  logic          net_err_i,
  output logic          net_space_o
);
  import iso_port_pkg::*;

  localparam int DEPTH  = PKT_BYTES * NUM_PKTS;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int IDX_W  = $clog2(PKT_BYTES);
  localparam int SLOT_W = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1;
  localparam int CNT_W  = $clog2(NUM_PKTS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_PKTS);

  dir_e              mode_q;
  logic              is_tx, pending, flush;
  logic              rdy_q, host_acc, host_wr;
  logic              wr_step, rd_step, w_last, r_last, w_mid_n, r_mid_n;
  logic [IDX_W-1:0]  w_idx, r_idx;
  logic [SLOT_W-1:0] w_slot, r_slot;
  logic [ADDR_W-1:0] w_addr, r_addr;
  logic [CNT_W-1:0]  comm_q, comm_n;
  logic              wr_ok, rd_ok, side_ok_n;
  logic [NUM_PKTS-1:0] err_bits;

  assign is_tx    = (mode_q == DIR_SEND);
  assign host_acc = host_valid_i && rdy_q;
  assign host_wr  = is_tx && host_acc;
  assign pending  = (dir_e'(dir_i) != mode_q);
  // R11: leaving send mode waits for an idle writer; R2: leaving receive is immediate
  assign flush    = pending && (!is_tx || ((w_idx == '0) && !host_wr));

  assign wr_ok       = (w_idx != '0) || (comm_q < FULL_CNT);
  assign rd_ok       = (r_idx != '0) || (comm_q != '0);
  assign net_space_o = !is_tx && wr_ok;
  assign net_avail_o = is_tx && rd_ok;

  assign wr_step = is_tx ? host_acc : (net_push_i && net_space_o);
  assign rd_step = is_tx ? (net_pop_i && net_avail_o) : host_acc;

  iso_port_cursor #(.PKT_BYTES(PKT_BYTES), .NUM_PKTS(NUM_PKTS),
                    .IDX_W(IDX_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst), .clr_i(flush), .step_i(wr_step),
    .idx_o(w_idx), .slot_o(w_slot), .addr_o(w_addr),
    .last_o(w_last), .mid_next_o(w_mid_n)
  );

  iso_port_cursor #(.PKT_BYTES(PKT_BYTES), .NUM_PKTS(NUM_PKTS),
                    .IDX_W(IDX_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .clr_i(flush), .step_i(rd_step),
    .idx_o(r_idx), .slot_o(r_slot), .addr_o(r_addr),
    .last_o(r_last), .mid_next_o(r_mid_n)
  );

  iso_port_ram #(.DW(DW), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk),
    .we_i(wr_step && !flush),
    .waddr_i(w_addr),
    .wdata_i(is_tx ? host_data_i : net_data_i),
    .re_a_i(is_tx && rd_step && !flush),
    .raddr_a_i(r_addr),
    .rdata_a_o(net_data_o),
    .raddr_b_i(r_addr),
    .rdata_b_o(host_data_o)
  );

  // complete packets held: written in full and not yet fully read
  assign comm_n    = flush ? '0 : comm_q + CNT_W'(w_last) - CNT_W'(r_last);
  assign side_ok_n = is_tx ? (comm_n < FULL_CNT) : (comm_n != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= DIR_RECV;
      comm_q <= '0;
    end else begin
      comm_q <= comm_n;
      if (flush) mode_q <= dir_e'(dir_i);
    end
  end

  // per-packet error flag, captured with the last pushed byte (R9)
  always_ff @(posedge clk) begin
    if (rst) err_bits <= '0;
    else if (!is_tx && w_last) err_bits[w_slot] <= net_err_i;
  end

  iso_port_ready #(.GAP_CYCLES(GAP_CYCLES)) u_rdy (
    .clk(clk), .rst(rst),
    .flush_i(flush),
    .mid_next_i(is_tx ? w_mid_n : r_mid_n),
    .pkt_end_i(is_tx ? w_last : r_last),
    .hold_mode_i(hold_mode_i),
    .buf_en_i(buf_en_i),
    .pending_i(pending),
    .side_ok_i(side_ok_n),
    .rdy_o(rdy_q)
  );

  assign rdy_o     = rdy_q;
  assign host_oe_o = !is_tx && rdy_q;
  assign err_o     = !is_tx && rdy_q && err_bits[r_slot];
  assign good_o    = !is_tx && rdy_q && !err_bits[r_slot];
endmodule

// File: rtl/iso_stream_port_chk.sv
module iso_stream_port_chk (
  input logic clk,
  input logic rst,
  input logic buf_en_i,
  input logic rdy_o,
  input logic err_o,
  input logic good_o,
  input logic host_oe_o,
  input logic net_avail_o,
  input logic net_space_o
);
  assert_ready_gap_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_o) |=> !rdy_o);

  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (rst)
    (err_o || good_o) |-> (rdy_o && !(err_o && good_o)));

  assert_oe_recv_R5: assert property (@(posedge clk) disable iff (rst)
    host_oe_o |-> (rdy_o && !net_avail_o));

  assert_disabled_low_R8: assert property (@(posedge clk) disable iff (rst)
    (!buf_en_i && !rdy_o) |=> !rdy_o);

  assert_sides_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(net_avail_o && net_space_o));
endmodule

bind iso_stream_port iso_stream_port_chk u_chk (.*);

// File: tb/iso_stream_port_test.sv
`timescale 1ns/1ps
module iso_stream_port_test;
  localparam int P = 4;
  localparam int N = 2;
  localparam int G = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir = 1'b1, hold = 1'b0, ben = 1'b1, hv = 1'b0, npop = 1'b0, npush = 1'b0, nerr = 1'b0;
  logic [7:0] hd = '0, nd = '0;
  logic [7:0] host_data_o, net_data_o;
  logic host_oe_o, rdy_o, err_o, good_o, net_avail_o, net_space_o;

  int checks = 0, errors = 0;
  int bytectr = 1;

  always #4 clk = ~clk;

  iso_stream_port #(.PKT_BYTES(P), .NUM_PKTS(N), .GAP_CYCLES(G), .DW(8)) uut (
    .clk(clk), .rst(rst), .dir_i(dir), .hold_mode_i(hold), .buf_en_i(ben),
    .host_valid_i(hv), .host_data_i(hd), .host_data_o(host_data_o),
    .host_oe_o(host_oe_o), .rdy_o(rdy_o), .err_o(err_o), .good_o(good_o),
    .net_pop_i(npop), .net_data_o(net_data_o), .net_avail_o(net_avail_o),
    .net_push_i(npush), .net_data_i(nd), .net_err_i(nerr), .net_space_o(net_space_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mode, m_comm, m_widx, m_ridx, m_gap;
  bit m_rdy, m_netchk, m_acc, m_tx, m_pend, m_flush, m_wl, m_rl, m_end, m_mid, m_side, m_nrdy;
  logic [7:0] m_netexp;
  logic [7:0] m_netq[$];
  logic [7:0] m_hostq[$];
  bit m_errq[$];

  always @(posedge clk) begin
    #2;
    m_netchk = 0;
    if (rst) begin
      m_mode = 1; m_comm = 0; m_widx = 0; m_ridx = 0; m_gap = 0; m_rdy = 0;
      m_netq.delete(); m_hostq.delete(); m_errq.delete();
    end else begin
      m_acc = hv && m_rdy;
      m_tx = (m_mode == 0);
      m_pend = (int'(dir) != m_mode);
      m_flush = m_pend && (!m_tx || (m_widx == 0 && !(m_tx && m_acc)));
      m_wl = 0; m_rl = 0;
      if (m_flush) begin
        m_mode = int'(dir); m_comm = 0; m_widx = 0; m_ridx = 0;
        m_netq.delete(); m_hostq.delete(); m_errq.delete();
        m_end = 0; m_mid = 0;
      end else begin
        if (m_tx) begin
          if (m_acc) begin
            m_netq.push_back(hd); m_widx++;
            if (m_widx == P) begin m_widx = 0; m_wl = 1; end
          end
          if (npop && (m_ridx != 0 || m_comm > 0)) begin
            m_netexp = m_netq.pop_front(); m_netchk = 1; m_ridx++;
            if (m_ridx == P) begin m_ridx = 0; m_rl = 1; end
          end
        end else begin
          if (npush && (m_widx != 0 || m_comm < N)) begin
            m_hostq.push_back(nd); m_widx++;
            if (m_widx == P) begin m_widx = 0; m_wl = 1; m_errq.push_back(nerr); end
          end
          if (m_acc) begin
            chk(host_data_o == m_hostq[0], "R5", "host_data_o", host_data_o, m_hostq[0]);
            void'(m_hostq.pop_front()); m_ridx++;
            if (m_ridx == P) begin m_ridx = 0; m_rl = 1; void'(m_errq.pop_front()); end
          end
        end
        m_comm = m_comm + int'(m_wl) - int'(m_rl);
        m_end = m_tx ? m_wl : m_rl;
        m_mid = m_tx ? (m_widx != 0) : (m_ridx != 0);
      end
      m_side = (m_mode == 0) ? (m_comm < N) : (m_comm > 0);
      if (m_flush) m_nrdy = 0;
      else if (m_mid) m_nrdy = 1;
      else if (m_end && !hold) m_nrdy = 0;
      else m_nrdy = ben && (int'(dir) == m_mode) && (m_gap == 0) && m_side;
      if (m_rdy && !m_nrdy) m_gap = G - 1;
      else if (m_gap > 0) m_gap--;
      m_rdy = m_nrdy;
    end
    // per-clock comparison
    chk(rdy_o == m_rdy, "R6 R7 R8", "rdy_o", rdy_o, m_rdy);
    chk(net_space_o == (m_mode == 1 && (m_widx != 0 || m_comm < N)), "R5", "net_space_o",
        net_space_o, (m_mode == 1 && (m_widx != 0 || m_comm < N)));
    chk(net_avail_o == (m_mode == 0 && (m_ridx != 0 || m_comm > 0)), "R3", "net_avail_o",
        net_avail_o, (m_mode == 0 && (m_ridx != 0 || m_comm > 0)));
    chk(host_oe_o == (m_mode == 1 && m_rdy), "R5", "host_oe_o", host_oe_o, (m_mode == 1 && m_rdy));
    if (m_netchk) chk(net_data_o == m_netexp, "R3", "net_data_o", net_data_o, m_netexp);
    if (m_mode == 1 && m_rdy && m_errq.size() > 0) begin
      chk(err_o == m_errq[0], "R9", "err_o", err_o, m_errq[0]);
      chk(good_o == !m_errq[0], "R9", "good_o", good_o, !m_errq[0]);
    end else begin
      chk(!err_o && !good_o, "R9", "flags idle", {err_o, good_o}, 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic send_bytes(input int n, input bit pause);
    int sent = 0;
    bit paused = 0;
    for (int guard = 0; guard < 2000 && sent < n; guard++) begin
      if (pause && sent == 2 && !paused) begin
        hv = 0; paused = 1;
        for (int k = 0; k < 2; k++) begin
          step();
          chk(rdy_o == 1'b1, "R10", "rdy_o during pause", rdy_o, 1);
        end
      end else begin
        hv = rdy_o; hd = 8'(bytectr);
        step();
        if (hv) begin sent++; bytectr++; end
      end
    end
    hv = 0;
  endtask

  task automatic recv_bytes(input int n);
    int got = 0;
    for (int guard = 0; guard < 2000 && got < n; guard++) begin
      hv = rdy_o;
      step();
      if (hv) got++;
    end
    hv = 0;
  endtask

  task automatic pop_bytes(input int n);
    int got = 0;
    for (int guard = 0; guard < 2000 && got < n; guard++) begin
      npop = net_avail_o;
      step();
      if (npop) got++;
    end
    npop = 0;
  endtask

  task automatic push_pkt(input bit bad);
    int sent = 0;
    for (int guard = 0; guard < 2000 && sent < P; guard++) begin
      npush = net_space_o; nd = 8'(bytectr); nerr = bad && (sent == P - 1);
      step();
      if (npush) begin sent++; bytectr++; end
    end
    npush = 0; nerr = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk(rdy_o == 0 && host_oe_o == 0, "R1", "rdy/oe after reset", {rdy_o, host_oe_o}, 0);
    chk(net_space_o == 1 && net_avail_o == 0, "R1", "space/avail after reset",
        {net_space_o, net_avail_o}, 2);
    chk(err_o == 0 && good_o == 0, "R1", "flags after reset", {err_o, good_o}, 0);

    // R2: switch to send
    dir = 0;
    step(); step();
    chk(rdy_o == 1 && net_space_o == 0, "R2", "send mode ready", {rdy_o, net_space_o}, 2);

    // R3/R10/R6: packet with a pause, drop-per-packet mode
    send_bytes(P, 1);
    chk(rdy_o == 0, "R6", "ready after packet end", rdy_o, 0);
    step();
    chk(rdy_o == 0, "R6", "ready second gap cycle", rdy_o, 0);
    step();
    chk(rdy_o == 1, "R6", "ready after gap", rdy_o, 1);
    chk(net_avail_o == 1, "R3", "packet available", net_avail_o, 1);

    // R4: fill, then offer bytes while full
    send_bytes(P, 0);
    repeat (2) step();
    for (int k = 0; k < 4; k++) begin
      hv = 1; hd = 8'hEE;
      step();
      chk(rdy_o == 0, "R4", "ready while full", rdy_o, 0);
    end
    hv = 0;
    pop_bytes(P);
    step();
    chk(rdy_o == 1, "R4", "ready after drain", rdy_o, 1);
    pop_bytes(P);
    step();

    // R7: hold mode keeps ready across a boundary
    hold = 1;
    send_bytes(P, 0);
    chk(rdy_o == 1, "R7", "ready at boundary", rdy_o, 1);
    send_bytes(P, 0);
    pop_bytes(2 * P);
    hold = 0;
    repeat (3) step();

    // R8: buffer access disabled
    ben = 0;
    step(); step();
    chk(rdy_o == 0, "R8", "ready with access off", rdy_o, 0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk(rdy_o == 0, "R8", "ready stays low", rdy_o, 0);
    end
    ben = 1;
    repeat (2) step();
    chk(rdy_o == 1, "R8", "ready after re-enable", rdy_o, 1);

    // R11: deferred switch to receive
    send_bytes(2, 0);
    dir = 1;
    step();
    chk(net_space_o == 0 && rdy_o == 1, "R11", "still sending mid packet",
        {net_space_o, rdy_o}, 1);
    send_bytes(P - 2, 0);
    step();
    chk(net_space_o == 1 && net_avail_o == 0, "R11", "flushed into receive",
        {net_space_o, net_avail_o}, 2);

    // R5/R9: receive a clean packet and a bad packet, then try pushing while full
    push_pkt(0);
    push_pkt(1);
    step();
    chk(net_space_o == 0, "R5", "no room when full", net_space_o, 0);
    for (int k = 0; k < 3; k++) begin
      npush = 1; nd = 8'h77;
      step();
    end
    npush = 0;
    chk(rdy_o == 1 && good_o == 1 && err_o == 0, "R9", "clean head packet",
        {rdy_o, good_o, err_o}, 6);
    recv_bytes(P);
    chk(err_o == 0 && good_o == 0, "R9", "flags drop with ready", {err_o, good_o}, 0);
    repeat (2) step();
    chk(rdy_o == 1 && err_o == 1 && good_o == 0, "R9", "bad head packet",
        {rdy_o, err_o, good_o}, 6);
    recv_bytes(P);
    step();

    // R2: immediate switch to send in the middle of a read
    push_pkt(0);
    repeat (2) step();
    recv_bytes(2);
    dir = 0;
    step();
    chk(host_oe_o == 0 && net_space_o == 0, "R2", "send after mid-read switch",
        {host_oe_o, net_space_o}, 0);
    step(); step();
    chk(rdy_o == 1 && net_avail_o == 0, "R2", "ready after flush", {rdy_o, net_avail_o}, 2);
    repeat (3) step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule